// File: doc/BRIEF.md
# SPI Serial Clock Divider with Linear and Power-of-Two Modes

This block turns a fast module clock into the serial clock of an SPI master. A 13-bit clock-control word selects one of two divide schemes. In linear mode the serial clock period is 2*(N+1) module-clock cycles, where N is an 8-bit field. In power-of-two mode the period is 2^M cycles, where M is a 4-bit field. Since the module clock must be at least twice the serial clock, the shortest period in either mode is two module-clock cycles.

A run enable is held high for the length of a transfer. While it is low, the serial clock rests at the idle level chosen by the polarity input. When it rises, the block captures the divide setting and the polarity, and restarts its counter so that the first half-period has full length. Settings that change during the transfer wait for the next start. Alongside the serial clock the block raises two single-cycle strobes. One marks the leading edge, where the clock leaves its idle level. The other marks the trailing edge, where it returns. A shift engine uses these strobes to sample and launch data without sensing the serial clock itself.

Top module: `spi_sck_divider`

## Requirements
- R1: While reset is asserted, and until the first start after reset, `sck`, `lead_stb` and `trail_stb` are all low when `cpol` is held low.
- R2: While `run_en` is low, `sck` equals the `cpol` value sampled at the previous clock edge, and neither strobe fires.
- R3: With `clk_ctl[12]` = 1 (linear mode), the serial clock has a period of 2*(N+1) module-clock cycles, with N = `clk_ctl[7:0]` and each half-period N+1 cycles (N=0 gives 2, N=255 gives 512).
- R4: With `clk_ctl[12]` = 0 (power-of-two mode) and M = `clk_ctl[11:8]` between 1 and 15, the period is 2^M cycles, with each half-period 2^(M-1) cycles.
- R5: In power-of-two mode with M = 0, the clock is not passed through undivided. It runs at the fastest legal rate: a period of 2 cycles, with `sck` toggling and a strobe firing on every cycle.
- R6: If `run_en` is first sampled high at clock edge k, then `sck` holds its idle level and neither strobe fires until edge k+H, where H is the half-period. At edge k+H the clock leaves the idle level and `lead_stb` rises.
- R7: Each strobe is one module-clock cycle wide and the two are never high together. They alternate strictly, starting with `lead_stb` after each start. `lead_stb` is high exactly in the cycle where `sck` first differs from the captured `cpol`, and `trail_stb` is high exactly in the cycle where it returns to it.
- R8: Changes to `clk_ctl` or `cpol` while `run_en` stays high do not affect the running clock. They take effect at the next low-to-high transition of `run_en`.
- R9: When `run_en` is sampled low, `sck` returns to the idle level at that edge and no strobe fires, even in the middle of a half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | High for the duration of a transfer |
| cpol | input | 1 | Idle level of the serial clock |
| clk_ctl | input | 13 | [7:0] linear factor N, [11:8] power exponent M, [12] mode select (1 = linear) |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse in the cycle sck leaves its idle level |
| trail_stb | output | 1 | One-cycle pulse in the cycle sck returns to its idle level |

## Verification
A half-period counter loaded with the wrong terminal value, or one that failed to clear on a start, changes the spacing of the strobes. The first strobe after a start is off by at least one cycle within H+1 cycles, so a per-cycle comparison with a behavioural model catches it on the first half-period. A phase bit or captured polarity that drifts makes `sck` disagree with the strobes: a leading strobe coincides with the wrong level, or two strobes of the same kind occur in a row, within one half-period. Settings captured at the wrong time show up as a period that changes in the middle of a transfer. The bench tests this by changing both the divider and the polarity between two strobes.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

  // Divider mode selected by the top bit of the clock-control word.
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;

  // Counter width: wide enough for the linear terminal N and for the largest
  // power-of-two terminal 2^(2^POW_W - 2) - 1.
  function automatic int unsigned term_width(input int unsigned lin_w,
                                             input int unsigned pow_w);
    int unsigned pw;
    pw = (32'd1 << pow_w) - 32'd2;
    if (pw < 1) pw = 1;
    return (lin_w > pw) ? lin_w : pw;
  endfunction

endpackage

// File: rtl/spi_sck_rst_sync.sv
module spi_sck_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/spi_sck_term_calc.sv
module spi_sck_term_calc
  import spi_sck_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int CNT_W = 14
) (
  input  logic [LIN_W-1:0] lin_n,
  input  logic [POW_W-1:0] pow_m,
  input  div_mode_e        mode,
  output logic [CNT_W-1:0] term
);
  // term = half-period length minus one, in module-clock cycles.
  always_comb begin
    term = '0;
    if (mode == DIV_LINEAR) begin
      term = CNT_W'(lin_n);
    end else if (pow_m != '0) begin
      term = (CNT_W'(1) << (pow_m - POW_W'(1))) - CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_sck_edge_gen.sv
module spi_sck_edge_gen #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cpol,
  input  logic [CNT_W-1:0] term_in,
  output logic             sck,
  output logic             lead_stb,
  output logic             trail_stb
);
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term_q;
  logic             phase_q, phase_d;
  logic             cpol_q, cpol_d;
  logic             lead_q, lead_d;
  logic             trail_q, trail_d;
  logic             cfg_load;
  logic             half_done;

  assign cfg_load  = run_en & ~active_q;
  assign half_done = (cnt_q == term_q);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    phase_d  = phase_q;
    cpol_d   = cpol_q;
    lead_d   = 1'b0;
    trail_d  = 1'b0;
    if (!run_en) begin
      active_d = 1'b0;
      cnt_d    = '0;
      phase_d  = 1'b0;
      cpol_d   = cpol;
    end else if (cfg_load) begin
      active_d = 1'b1;
      cnt_d    = '0;
      phase_d  = 1'b0;
      cpol_d   = cpol;
    end else if (half_done) begin
      cnt_d    = '0;
      phase_d  = ~phase_q;
      lead_d   = ~phase_q;
      trail_d  = phase_q;
    end else begin
      cnt_d    = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      cpol_q   <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      phase_q  <= phase_d;
      cpol_q   <= cpol_d;
      lead_q   <= lead_d;
      trail_q  <= trail_d;
    end
  end

  // Divider terminal is captured only on the idle-to-active transition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
    end else if (cfg_load) begin
      term_q <= term_in;
    end
  end

  assign sck       = cpol_q ^ phase_q;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import spi_sck_pkg::*;
#(
  parameter  int LIN_W = 8,
  parameter  int POW_W = 4,
  localparam int CTL_W = LIN_W + POW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cpol,
  input  logic [CTL_W-1:0] clk_ctl,
  output logic             sck,
  output logic             lead_stb,
  output logic             trail_stb
);
  localparam int CNT_W = int'(term_width(LIN_W, POW_W));

  logic             rst_sync_n;
  logic [LIN_W-1:0] lin_n;
  logic [POW_W-1:0] pow_m;
  div_mode_e        mode;
  logic [CNT_W-1:0] term;

  assign lin_n = clk_ctl[LIN_W-1:0];
  assign pow_m = clk_ctl[LIN_W +: POW_W];
  assign mode  = div_mode_e'(clk_ctl[CTL_W-1]);

  spi_sck_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spi_sck_term_calc #(
    .LIN_W (LIN_W),
    .POW_W (POW_W),
    .CNT_W (CNT_W)
  ) u_term (
    .lin_n (lin_n),
    .pow_m (pow_m),
    .mode  (mode),
    .term  (term)
  );

  spi_sck_edge_gen #(
    .CNT_W (CNT_W)
  ) u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_en    (run_en),
    .cpol      (cpol),
    .term_in   (term),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );
endmodule

// File: rtl/spi_sck_divider_chk.sv
module spi_sck_divider_chk (
  input logic clk,
  input logic rst_ns,
  input logic run_en,
  input logic cpol,
  input logic sck,
  input logic lead_stb,
  input logic trail_stb
);
  logic last_lead_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      last_lead_q <= 1'b0;
    end else if (!run_en) begin
      last_lead_q <= 1'b0;
    end else if (lead_stb) begin
      last_lead_q <= 1'b1;
    end else if (trail_stb) begin
      last_lead_q <= 1'b0;
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !(lead_stb && trail_stb));

  p_lead_edge_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    lead_stb |-> !$stable(sck));

  p_trail_edge_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    trail_stb |-> !$stable(sck));

  p_alt_lead_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    lead_stb |-> !last_lead_q);

  p_alt_trail_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    trail_stb |-> last_lead_q);

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    !run_en |=> (sck == $past(cpol)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    !run_en |=> (!lead_stb && !trail_stb));

  p_start_full_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(run_en) |=> (!lead_stb && !trail_stb && sck == $past(cpol)));
endmodule

bind spi_sck_divider spi_sck_divider_chk u_chk (
  .clk       (clk),
  .rst_ns    (rst_sync_n),
  .run_en    (run_en),
  .cpol      (cpol),
  .sck       (sck),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb)
);

// File: tb/tb_spi_sck_divider.sv
module tb_spi_sck_divider;
  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic        cpol;
  logic [12:0] clk_ctl;
  logic        sck;
  logic        lead_stb;
  logic        trail_stb;

  int checks = 0;
  int fails  = 0;

  spi_sck_divider dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cpol      (cpol),
    .clk_ctl   (clk_ctl),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_act, m_cnt, m_half, m_ph, m_pol, m_lead, m_trail;

  function automatic int half_of(input logic [12:0] c);
    int m;
    if (c[12]) return int'(c[7:0]) + 1;
    m = int'(c[11:8]);
    if (m == 0) return 1;
    return 1 << (m - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_half = 1; m_ph = 0; m_pol = 0; m_lead = 0; m_trail = 0;
    end else begin
      m_lead = 0; m_trail = 0;
      if (!run_en) begin
        m_act = 0; m_cnt = 0; m_ph = 0; m_pol = int'(cpol);
      end else if (m_act == 0) begin
        m_act = 1; m_cnt = 0; m_ph = 0; m_pol = int'(cpol); m_half = half_of(clk_ctl);
      end else if (m_cnt == m_half - 1) begin
        m_cnt = 0; m_ph = 1 - m_ph;
        if (m_ph == 1) m_lead = 1; else m_trail = 1;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge (R6/R7 timing, R8 capture).
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (sck !== logic'(m_pol ^ m_ph) || lead_stb !== logic'(m_lead[0]) ||
          trail_stb !== logic'(m_trail[0])) begin
        fails++;
        $display("FAIL R7 model compare: actual sck/lead/trail=%b%b%b expected=%0d%0d%0d",
                 sck, lead_stb, trail_stb, m_pol ^ m_ph, m_lead, m_trail);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] lin(input int n);
    return {1'b1, 4'd0, 8'(n)};
  endfunction

  function automatic logic [12:0] pw2(input int m);
    return {1'b0, 4'(m), 8'd0};
  endfunction

  task automatic wait_lead(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!lead_stb && n < 5000);
  endtask

  task automatic wait_trail(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!trail_stb && n < 5000);
  endtask

  task automatic stop_run(input logic pol);
    #1 run_en = 1'b0;
    @(negedge clk);
    check(sck == pol && !lead_stb && !trail_stb, "R9", "idle after stop sck",
          int'(sck), int'(pol));
    repeat (3) @(negedge clk);
  endtask

  // Starts a transfer, measures first delay, both half-periods, then stops.
  task automatic measure(input logic [12:0] c, input logic pol, input int h,
                         input string req);
    int n;
    clk_ctl = c; cpol = pol; run_en = 1'b1;
    wait_lead(n);
    check(n == h + 1, "R6", "first lead delay", n, h + 1);
    check(sck == ~pol, "R7", "sck at lead", int'(sck), int'(~pol));
    #1;
    wait_trail(n);
    check(n == h, req, "lead-to-trail cycles", n, h);
    check(sck == pol, "R7", "sck at trail", int'(sck), int'(pol));
    #1;
    wait_lead(n);
    check(n == h, req, "trail-to-lead cycles", n, h);
    stop_run(pol);
  endtask

  initial begin
    int n;
    rst_n = 1'b1; run_en = 1'b0; cpol = 1'b0; clk_ctl = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sck == 1'b0 && !lead_stb && !trail_stb, "R1", "outputs in reset",
          int'({sck, lead_stb, trail_stb}), 0);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sck == 1'b0 && !lead_stb && !trail_stb, "R1", "outputs after reset",
          int'({sck, lead_stb, trail_stb}), 0);

    #1 cpol = 1'b1;
    repeat (3) @(negedge clk);
    check(sck == 1'b1 && !lead_stb && !trail_stb, "R2", "idle level cpol=1",
          int'(sck), 1);
    #1 cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(sck == 1'b0, "R2", "idle level cpol=0", int'(sck), 0);

    #1;
    measure(lin(0),   1'b0, 1,   "R3");
    #1;
    measure(lin(3),   1'b1, 4,   "R3");
    #1;
    measure(lin(255), 1'b0, 256, "R3");
    #1;
    measure(pw2(1),   1'b0, 1,   "R4");
    #1;
    measure(pw2(3),   1'b1, 4,   "R4");
    #1;
    measure(pw2(5),   1'b0, 16,  "R4");
    #1;
    measure(pw2(0),   1'b1, 1,   "R5");

    // R5: with M=0 a strobe fires on every cycle once running.
    #1 clk_ctl = pw2(0); cpol = 1'b0; run_en = 1'b1;
    wait_lead(n);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(lead_stb ^ trail_stb, "R5", "strobe every cycle", int'({lead_stb, trail_stb}), 1);
    end
    stop_run(1'b0);

    // R8: change divider and polarity mid-transfer; the running clock ignores it.
    #1 clk_ctl = lin(3); cpol = 1'b0; run_en = 1'b1;
    wait_lead(n);
    #1 clk_ctl = lin(0); cpol = 1'b1;
    wait_trail(n);
    check(n == 4, "R8", "half-period after mid change", n, 4);
    check(sck == 1'b0, "R8", "captured polarity kept", int'(sck), 0);
    #1;
    wait_lead(n);
    check(n == 4, "R8", "second half after mid change", n, 4);
    stop_run(1'b1);
    #1;
    measure(lin(0), 1'b1, 1, "R8");

    // R9: stop in the middle of a long half-period.
    #1 clk_ctl = pw2(6); cpol = 1'b0; run_en = 1'b1;
    wait_lead(n);
    repeat (10) @(negedge clk);
    check(sck == 1'b1, "R9", "high mid half-period", int'(sck), 1);
    stop_run(1'b0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule